// File: doc/BRIEF.md
# Master/Slave Synchronous Serial Port

This block is an eight-bit, full-duplex clocked serial port. It moves one byte per transfer. The byte goes out on `sout` while a byte comes in on `sin`. In master mode the block makes its own shift clock from the system clock and drives it on `sclk_o`. In slave mode it takes the shift clock from `sclk_i`, passes it through a two-flop synchronizer and detects its edges in the system clock domain.

Software sets up the port through a small write port. That port holds a two-bit clock mode, a bit-order flag and a ready-output enable. A `start` pulse loads the transmit byte and begins a transfer. A transfer always stops by itself after eight shift clocks. The `done` flag then rises and `rx_data` holds the received byte. When the ready option is enabled, the general-purpose output pin `gp_pin` is taken over by an active-low ready signal. That signal tells the far side whether a transfer is armed.

Top module: `sio_port`

## Requirements
- R1: After reset the mode reads 11 (slave) and the order flag reads 0. `busy`, `done`, `sclk_o` and `sclk_oe` are all low.
- R2: Mode 00, 01 and 10 select master operation, where `sclk_o` toggles every 1, 2 or 4 system clocks. This gives an SCLK period of 2, 4 or 8 cycles. Mode 11 selects slave operation, where `sclk_oe` is low and `sclk_i` is the shift clock.
- R3: In master mode one transfer gives exactly eight high pulses on `sclk_o`. After the eighth pulse `sclk_o` stays low until the next start.
- R4: In slave mode, `sclk_i` edges that arrive after the eighth falling edge do not change `rx_data` or `done`, and `busy` stays low.
- R5: An order flag of 1 moves bit 7 first and an order flag of 0 moves bit 0 first. The same order applies to both `sout` and `sin`.
- R6: Bits are sampled from `sin` on the rising SCLK edge. `sout` changes only after a falling SCLK edge. The first bit is present on `sout` as soon as the transfer has started.
- R7: `start` loads `tx_data`, clears `done` and sets `busy`. The eighth falling edge clears `busy` and sets `done`, and `rx_data` then equals the byte received on `sin`.
- R8: When the ready option is 0, `gp_pin` follows `gpo_data`. When it is 1, `gp_pin` is low exactly while a transfer is in progress, and `gpo_data` has no effect on it.
- R9: A configuration write while `busy` is high leaves the mode and the order flag unchanged.
- R10: A `start` while `busy` is high is ignored, so the byte in flight is not replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Clock mode to write (00/01/10 master, 11 slave) |
| cfg_msb_first | input | 1 | Bit order to write (1 = MSB first) |
| cfg_ready_en | input | 1 | Ready-output option to write |
| start | input | 1 | Start-transfer pulse |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Received byte |
| mode_q | output | 2 | Current clock mode |
| msb_first_q | output | 1 | Current bit order |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| gpo_data | input | 1 | General-purpose output bit |
| gp_pin | output | 1 | General-purpose pin, or the active-low ready signal |
| sclk_i | input | 1 | External shift clock (slave) |
| sclk_o | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | Output enable for sclk_o |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |

## Verification
Two situations are hard to reach from the ports. The first is the masking of surplus slave clock edges. The bench finishes a full eight-pulse slave transfer, then drives three more `sclk_i` pulses with an inverted `sin`, and checks that the received byte and the flags stay the same. The second is a configuration write or a restart in the middle of a byte. The bench issues a slow master transfer and, partway through, writes a new mode and order and pulses `start` with different data. It then rebuilds the byte seen on `sout` and checks that it still matches the first byte in the first order.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int SIO_W = 8;

  typedef enum logic [1:0] {
    MODE_DIV1  = 2'b00,
    MODE_DIV2  = 2'b01,
    MODE_DIV4  = 2'b10,
    MODE_SLAVE = 2'b11
  } sio_mode_e;

  // Number of system clocks between master SCLK toggles.
  function automatic logic [2:0] half_period(input logic [1:0] mode);
    case (mode)
      2'b00:   half_period = 3'd1;
      2'b01:   half_period = 3'd2;
      2'b10:   half_period = 3'd4;
      default: half_period = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/sio_master_clk.sv
module sio_master_clk
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] mode,
  output logic       sclk,
  output logic       rise_ev,
  output logic       fall_ev
);

  logic [2:0] div_q;
  logic       sclk_q;
  logic       tick;

  assign tick    = run && (div_q == (half_period(mode) - 3'd1));
  assign rise_ev = tick && !sclk_q;
  assign fall_ev = tick && sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 3'd1;
    end
  end

  // R2: the divider never passes the selected half period
  a_r2_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_q < half_period(mode)));

endmodule

// File: rtl/sio_slave_sync.sv
module sio_slave_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sclk_in,
  output logic rise_ev,
  output logic fall_ev
);

  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sclk_in};
  end

  assign rise_ev = run && sync_q[1] && !sync_q[2];
  assign fall_ev = run && !sync_q[1] && sync_q[2];

  // R4: edges are never reported outside a transfer
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(rise_ev || fall_ev));

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         msb_first,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] data,
  output logic         last_ev
);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic          samp_q;

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] cur,
                                            input logic bit_in,
                                            input logic msb);
    if (msb) shift_in = {cur[W-2:0], bit_in};
    else     shift_in = {bit_in, cur[W-1:1]};
  endfunction

  assign sout    = msb_first ? sr_q[W-1] : sr_q[0];
  assign data    = sr_q;
  assign last_ev = fall_ev && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      samp_q <= 1'b0;
    end else if (load) begin
      sr_q   <= load_data;
      cnt_q  <= '0;
    end else begin
      if (rise_ev) samp_q <= sin;
      if (fall_ev) begin
        sr_q  <= shift_in(sr_q, samp_q, msb_first);
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R4: the shift register holds outside a transfer
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(sr_q));
  // R6: no shift event arrives while idle
  a_r6_no_idle_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !fall_ev);

endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_msb_first,
  input  logic       cfg_ready_en,
  input  logic       start,
  input  logic [7:0] tx_data,
  output logic [7:0] rx_data,
  output logic [1:0] mode_q,
  output logic       msb_first_q,
  output logic       busy,
  output logic       done,
  input  logic       gpo_data,
  output logic       gp_pin,
  input  logic       sclk_i,
  output logic       sclk_o,
  output logic       sclk_oe,
  input  logic       sin,
  output logic       sout
);

  logic [1:0] mode_r;
  logic       msb_r, rdy_en_r, busy_r, done_r;
  logic       is_master, load;
  logic       m_sclk, m_rise, m_fall, s_rise, s_fall;
  logic       rise_ev, fall_ev, last_ev;

  assign is_master = (mode_r != MODE_SLAVE);
  assign load      = start && !busy_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= MODE_SLAVE;
      msb_r    <= 1'b0;
      rdy_en_r <= 1'b0;
    end else if (cfg_we) begin
      rdy_en_r <= cfg_ready_en;
      if (!busy_r) begin
        mode_r <= cfg_mode;
        msb_r  <= cfg_msb_first;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else if (load) begin
      busy_r <= 1'b1;
      done_r <= 1'b0;
    end else if (last_ev) begin
      busy_r <= 1'b0;
      done_r <= 1'b1;
    end
  end

  sio_master_clk u_mclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_r && is_master),
    .mode    (mode_r),
    .sclk    (m_sclk),
    .rise_ev (m_rise),
    .fall_ev (m_fall)
  );

  sio_slave_sync u_ssync (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_r && !is_master),
    .sclk_in (sclk_i),
    .rise_ev (s_rise),
    .fall_ev (s_fall)
  );

  assign rise_ev = is_master ? m_rise : s_rise;
  assign fall_ev = is_master ? m_fall : s_fall;

  sio_shifter #(.W(SIO_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_r),
    .load      (load),
    .load_data (tx_data),
    .msb_first (msb_r),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .sin       (sin),
    .sout      (sout),
    .data      (rx_data),
    .last_ev   (last_ev)
  );

  assign mode_q      = mode_r;
  assign msb_first_q = msb_r;
  assign busy        = busy_r;
  assign done        = done_r;
  assign sclk_o      = is_master && m_sclk;
  assign sclk_oe     = is_master;
  assign gp_pin      = rdy_en_r ? !busy_r : gpo_data;

  // R3: the generated clock is parked low when no transfer runs
  a_r3_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_r |-> !sclk_o);
  // R9: the mode does not change across a busy cycle pair
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && $past(busy_r)) |-> ($stable(mode_r) && $stable(msb_r)));
  // R7: done and busy are never high together
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |-> !busy_r);
  // R2: slave mode never drives the clock pin
  a_r2_slave_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == MODE_SLAVE) |-> !sclk_oe);
  // R6: sout holds while the master clock stays high
  a_r6_sout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && sclk_o && $past(sclk_o)) |-> $stable(sout));

endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_we = 0, cfg_msb_first = 0, cfg_ready_en = 0, start = 0;
  logic [1:0] cfg_mode = 2'b11;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic [1:0] mode_q;
  logic       msb_first_q, busy, done, gpo_data = 0, gp_pin;
  logic       sclk_i = 0, sclk_o, sclk_oe, sin = 0, sout;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_port dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] v, input int k, input logic msb);
    return msb ? v[7-k] : v[k];
  endfunction

  task automatic write_cfg(input logic [1:0] m, input logic msb, input logic rdy);
    @(negedge clk);
    cfg_mode = m; cfg_msb_first = msb; cfg_ready_en = rdy; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode", mode_q, 2'b11);
    chk("R1 order", msb_first_q, 0);
    chk("R1 busy/done", {busy, done}, 2'b00);
    chk("R1 sclk", {sclk_o, sclk_oe}, 2'b00);
  endtask

  task automatic t_gp_pin;
    write_cfg(2'b11, 0, 0);
    gpo_data = 1; @(negedge clk); chk("R8 gp follows 1", gp_pin, 1);
    gpo_data = 0; @(negedge clk); chk("R8 gp follows 0", gp_pin, 0);
    write_cfg(2'b11, 0, 1);
    chk("R8 ready idle high", gp_pin, 1);
    gpo_data = 1; @(negedge clk); gpo_data = 0; @(negedge clk);
    chk("R8 gpo ignored", gp_pin, 1);
  endtask

  // Master transfer; bench plays the external slave.
  task automatic master_xfer(input logic [1:0] m, input logic msb, input logic [7:0] tx,
                             input logic [7:0] ext, input logic meddle, input logic rdy);
    int k = 0, rises = 0, n = 0, r0 = 0, r1 = 0;
    logic prev = 0, pin_ok = 1;
    logic [7:0] seen = 8'h00;
    write_cfg(m, msb, rdy);
    sin = bit_at(ext, 0, msb);
    tx_data = tx; start = 1;
    @(negedge clk); start = 0;
    chk("R7 busy after start", busy, 1);
    for (int i = 0; i < 400; i++) begin
      n++;
      if (rdy && busy && gp_pin !== 0) pin_ok = 0;
      if (sclk_o && !prev) begin
        if (rises < 8) seen[msb ? 7-rises : rises] = sout;
        if (rises == 0) r0 = n;
        if (rises == 1) r1 = n;
        rises++;
      end
      if (!sclk_o && prev) begin
        k++;
        if (k < 8) sin = bit_at(ext, k, msb);
      end
      prev = sclk_o;
      if (meddle && n == 12) begin
        cfg_mode = 2'b00; cfg_msb_first = !msb; cfg_we = 1;
        tx_data = ~tx; start = 1;
      end else begin
        cfg_we = 0; start = 0;
      end
      if (done) break;
      @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sclk_o) rises++;
    end
    chk("R3 eight pulses then low", rises, 8);
    chk("R3 parked low", sclk_o, 0);
    chk("R7 done", {busy, done}, 2'b01);
    chk("R7 rx byte", rx_data, ext);
    chk("R6 sout byte", seen, tx);
    chk("R2 sclk period", r1 - r0, 2 * (1 << m));
    chk("R2 clock driven", sclk_oe, 1);
    if (rdy) begin
      chk("R8 ready low during xfer", pin_ok, 1);
      chk("R8 ready released", gp_pin, 1);
    end
    if (meddle) begin
      chk("R9 mode kept", mode_q, m);
      chk("R9 order kept", msb_first_q, msb);
      chk("R10 restart ignored (sout)", seen, tx);
    end
  endtask

  task automatic slave_pulse;
    repeat (4) @(negedge clk);
    sclk_i = 1;
    repeat (4) @(negedge clk);
    sclk_i = 0;
  endtask

  // Slave transfer; bench plays the external master.
  task automatic slave_xfer(input logic msb, input logic [7:0] tx, input logic [7:0] ext);
    logic [7:0] seen = 8'h00;
    write_cfg(2'b11, msb, 0);
    chk("R2 slave undriven", sclk_oe, 0);
    tx_data = tx; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 8; i++) begin
      sin = bit_at(ext, i, msb);
      repeat (4) @(negedge clk);
      seen[msb ? 7-i : i] = sout;
      sclk_i = 1;
      repeat (4) @(negedge clk);
      sclk_i = 0;
    end
    repeat (6) @(negedge clk);
    chk("R7 slave done", {busy, done}, 2'b01);
    chk("R5 slave rx order", rx_data, ext);
    chk("R5 slave tx order", seen, tx);
    sin = ~sin;
    for (int i = 0; i < 3; i++) slave_pulse();
    repeat (6) @(negedge clk);
    chk("R4 extra edges rx", rx_data, ext);
    chk("R4 extra edges flags", {busy, done}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_gp_pin();
    master_xfer(2'b00, 1, 8'hA5, 8'h3C, 0, 0);
    master_xfer(2'b01, 0, 8'h1E, 8'hC9, 0, 1);
    master_xfer(2'b10, 1, 8'h81, 8'h7E, 0, 0);
    master_xfer(2'b10, 0, 8'h6B, 8'hD2, 1, 0);
    slave_xfer(1, 8'h96, 8'h5A);
    slave_xfer(0, 8'h0F, 8'hE1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule